// File: doc/BRIEF.md
# Variable-Width CRC Input Word Queue

This block is the input queue that sits in front of a CRC engine. Software loads data through a 32-bit holding register, one byte lane at a time. The word width is programmable from 1 to 32 bits. A word enters the queue when software writes the byte lane that holds the most significant bit of the configured width. Lanes below that byte are only latched into the holding register. This lets a narrow word be committed with a single byte write. A wide word is built up by writing the lower lanes first and the top lane last.

The number of words the queue can hold depends on the width. Narrow words get a deeper queue and wide words a shallower one. This keeps the storage footprint fixed. The queue reports how many valid words it holds, plus full, empty and sticky overflow flags. When the engine asks for the next word, the oldest entry moves into a buffer register that the engine shifts from. Dropping the enable input flushes everything.

Top module: `crc_word_queue`

## Requirements
- R1: `width_cfg` holds the word width minus one. Every queued word is masked to that width, so bits at or above the width read as zero on `pop_data`.
- R2: The capacity is 4 words when `width_cfg` is 16 to 31, 8 words when it is 8 to 15, and 16 words when it is 0 to 7. `full` is high while `word_count` equals that capacity.
- R3: Byte lane k of `lane_we` loads `wr_data[8k+7:8k]` into the holding register. A word is committed only in a cycle where lane `width_cfg[4:3]` is strobed. Strobes on other lanes leave `word_count` unchanged.
- R4: A commit stores the holding register merged with the lanes written in that cycle. Lanes written in earlier cycles therefore become part of the word.
- R5: `word_count` and `empty` reflect a commit or pop from the clock after it. `empty` is high exactly when `word_count` is zero. After reset, the count is zero and `empty` is high.
- R6: `pop_req` with at least one word queued sets `pop_valid` for one cycle on the next clock. On that clock `pop_data` carries the oldest word, and the count drops by one. Words leave in commit order. A commit and a pop in the same cycle leave the count unchanged.
- R7: `pop_req` while empty is ignored. `pop_valid` stays low, `pop_data` keeps its value, and the count stays zero.
- R8: A commit when the count is already at capacity is dropped, even if a pop happens in the same cycle. It sets `overflow`, which stays high until a flush. The queued words are unaffected.
- R9: While `enable` is low, on every clock the count goes to zero, the holding register, `overflow`, `pop_valid` and `pop_data` are cleared, and lane writes and pops are ignored.
- R10: For widths under 8 bits, a write to lane 0 commits the word. The unused upper bits of that byte are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; low flushes the queue |
| width_cfg | input | 5 | Word width minus one |
| lane_we | input | 4 | Byte-lane write strobes |
| wr_data | input | 32 | Write data, byte lane k at bits 8k+7:8k |
| pop_req | input | 1 | Engine request for the next word |
| pop_data | output | 32 | Buffer register loaded with the popped word |
| pop_valid | output | 1 | One-cycle pulse when `pop_data` was loaded |
| word_count | output | 5 | Number of queued words |
| full | output | 1 | Count equals the capacity for the width |
| empty | output | 1 | Count is zero |
| overflow | output | 1 | Sticky: a commit was dropped while full |

## Verification
The queue is exercised at four widths: 32, 24, 16/12 and 6 bits. This shows that the commit lane, the mask and the capacity all follow `width_cfg`, rather than one fixed setting. Wide words are built lane by lane, and a strobe on a lane above the width is issued alone. These patterns separate a correct commit trigger from one that fires on any write or on the top lane only. Filling to capacity and then pushing once more separates the full threshold and the dropped commit from an off-by-one. Pops on an empty queue, and a pop paired with a commit at and below capacity, show the gating of the count update.

// File: rtl/crc_wq_pkg.sv
package crc_wq_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LANES     = WORD_W / BYTE_W;
    localparam int unsigned CFG_W     = $clog2(WORD_W);
    localparam int unsigned LANE_W    = $clog2(LANES);
    localparam int unsigned MAX_DEPTH = 16;
    localparam int unsigned PTR_W     = $clog2(MAX_DEPTH);
    localparam int unsigned CNT_W     = PTR_W + 1;

    // width thresholds (field values) and the capacity that goes with each band
    localparam int unsigned WIDE_CFG_MIN = 16;
    localparam int unsigned MID_CFG_MIN  = 8;
    localparam int unsigned WIDE_DEPTH   = MAX_DEPTH / 4;
    localparam int unsigned MID_DEPTH    = MAX_DEPTH / 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t hold;
    } cap_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic             ovf;
    } ctrl_state_t;

    typedef struct packed {
        word_t data;
        logic  valid;
    } buf_state_t;

    function automatic logic [CNT_W-1:0] depth_of(input logic [CFG_W-1:0] cfg);
        if (cfg >= CFG_W'(WIDE_CFG_MIN)) return CNT_W'(WIDE_DEPTH);
        else if (cfg >= CFG_W'(MID_CFG_MIN)) return CNT_W'(MID_DEPTH);
        else return CNT_W'(MAX_DEPTH);
    endfunction

    function automatic word_t mask_of(input logic [CFG_W-1:0] cfg);
        word_t ones;
        ones = '1;
        return ones >> (CFG_W'(WORD_W - 1) - cfg);
    endfunction

    function automatic logic [LANE_W-1:0] lane_of(input logic [CFG_W-1:0] cfg);
        return cfg[CFG_W-1 -: LANE_W];
    endfunction

endpackage

// File: rtl/crc_wq_capture.sv
module crc_wq_capture
    import crc_wq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [CFG_W-1:0]     width_cfg,
    input  logic [LANES-1:0]     lane_we,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 commit,
    output word_t                commit_word
);

    cap_state_t st_d, st_q;
    word_t      merged;

    // byte-lane merge of the write data into the holding register
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*BYTE_W +: BYTE_W] = lane_we[l] ? wr_data[l*BYTE_W +: BYTE_W]
                                                       : st_q.hold[l*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d        = st_q;
        commit      = 1'b0;
        commit_word = merged & mask_of(width_cfg);
        if (!enable) begin
            st_d.hold = '0;
        end else begin
            st_d.hold = merged;
            commit    = lane_we[lane_of(width_cfg)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/crc_wq_ctrl.sv
module crc_wq_ctrl
    import crc_wq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [CFG_W-1:0]     width_cfg,
    input  logic                 commit,
    input  logic                 pop_req,
    output logic                 push_ok,
    output logic                 pop_ok,
    output logic [PTR_W-1:0]     wptr,
    output logic [PTR_W-1:0]     rptr,
    output logic [CNT_W-1:0]     count,
    output logic                 full,
    output logic                 empty,
    output logic                 overflow
);

    ctrl_state_t      st_d, st_q;
    logic [CNT_W-1:0] cap;

    always_comb begin
        cap     = depth_of(width_cfg);
        full    = (st_q.cnt >= cap);
        empty   = (st_q.cnt == '0);
        push_ok = enable && commit && !full;
        pop_ok  = enable && pop_req && !empty;
        st_d    = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = st_q.wptr + PTR_W'(1);
            if (pop_ok)  st_d.rptr = st_q.rptr + PTR_W'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
                2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
            if (commit && full) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr     = st_q.wptr;
    assign rptr     = st_q.rptr;
    assign count    = st_q.cnt;
    assign overflow = st_q.ovf;

endmodule

// File: rtl/crc_wq_store.sv
module crc_wq_store
    import crc_wq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 push_ok,
    input  logic                 pop_ok,
    input  logic [PTR_W-1:0]     wptr,
    input  logic [PTR_W-1:0]     rptr,
    input  word_t                push_word,
    output word_t                out_data,
    output logic                 out_valid
);

    word_t      mem_d [MAX_DEPTH];
    word_t      mem_q [MAX_DEPTH];
    buf_state_t buf_d, buf_q;

    always_comb begin
        mem_d = mem_q;
        buf_d = buf_q;
        if (push_ok) mem_d[wptr] = push_word;
        if (!enable) begin
            buf_d = '0;
        end else begin
            buf_d.valid = pop_ok;
            if (pop_ok) buf_d.data = mem_q[rptr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MAX_DEPTH); i++) mem_q[i] <= '0;
            buf_q <= '0;
        end else begin
            mem_q <= mem_d;
            buf_q <= buf_d;
        end
    end

    assign out_data  = buf_q.data;
    assign out_valid = buf_q.valid;

endmodule

// File: rtl/crc_word_queue.sv
module crc_word_queue
    import crc_wq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [CFG_W-1:0]     width_cfg,
    input  logic [LANES-1:0]     lane_we,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 pop_req,
    output logic [WORD_W-1:0]    pop_data,
    output logic                 pop_valid,
    output logic [CNT_W-1:0]     word_count,
    output logic                 full,
    output logic                 empty,
    output logic                 overflow
);

    logic             commit;
    word_t            commit_word;
    logic             push_ok;
    logic             pop_ok;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    crc_wq_capture u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .width_cfg   (width_cfg),
        .lane_we     (lane_we),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_word (commit_word)
    );

    crc_wq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .width_cfg (width_cfg),
        .commit    (commit),
        .pop_req   (pop_req),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wptr      (wptr),
        .rptr      (rptr),
        .count     (word_count),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow)
    );

    crc_wq_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wptr      (wptr),
        .rptr      (rptr),
        .push_word (commit_word),
        .out_data  (pop_data),
        .out_valid (pop_valid)
    );

endmodule

// File: rtl/crc_wq_checker.sv
module crc_wq_checker
    import crc_wq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic [CFG_W-1:0]     width_cfg,
    input logic [LANES-1:0]     lane_we,
    input logic                 pop_req,
    input logic [WORD_W-1:0]    pop_data,
    input logic                 pop_valid,
    input logic [CNT_W-1:0]     word_count,
    input logic                 full,
    input logic                 empty,
    input logic                 overflow
);

    logic top_lane;
    assign top_lane = lane_we[lane_of(width_cfg)];

    p_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);

    p_commit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enable && top_lane && !full && !(pop_req && !empty)
        |=> word_count == $past(word_count) + CNT_W'(1));

    p_pop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable && pop_req && !empty && !top_lane
        |=> pop_valid && word_count == $past(word_count) - CNT_W'(1));

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enable && empty && pop_req |=> !pop_valid && $stable(pop_data));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && full && top_lane |=> overflow);

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enable && overflow |=> overflow);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> word_count == '0 && !overflow && !pop_valid);

endmodule

bind crc_word_queue crc_wq_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .width_cfg  (width_cfg),
    .lane_we    (lane_we),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .pop_valid  (pop_valid),
    .word_count (word_count),
    .full       (full),
    .empty      (empty),
    .overflow   (overflow)
);

// File: tb/crc_word_queue_tb.sv
`timescale 1ns/1ps
module crc_word_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  width_cfg = 5'd31;
    logic [3:0]  lane_we = 4'h0;
    logic [31:0] wr_data = '0;
    logic        pop_req = 1'b0;
    logic [31:0] pop_data;
    logic        pop_valid;
    logic [4:0]  word_count;
    logic        full;
    logic        empty;
    logic        overflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // behavioural reference state
    logic [31:0] m_q[$];
    logic [31:0] m_hold = '0;
    logic [31:0] m_pdata = '0;
    logic        m_pvalid = 1'b0;
    logic        m_ovf = 1'b0;

    always #2 clk = ~clk;

    crc_word_queue dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .width_cfg  (width_cfg),
        .lane_we    (lane_we),
        .wr_data    (wr_data),
        .pop_req    (pop_req),
        .pop_data   (pop_data),
        .pop_valid  (pop_valid),
        .word_count (word_count),
        .full       (full),
        .empty      (empty),
        .overflow   (overflow)
    );

    function automatic int cap_for(input int cfg);
        if (cfg > 15) return 4;
        if (cfg > 7) return 8;
        return 16;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [31:0] merged;
        int          sz;
        bit          commit;
        merged = m_hold;
        if (!enable) begin
            m_q.delete();
            m_hold   = '0;
            m_ovf    = 1'b0;
            m_pvalid = 1'b0;
            m_pdata  = '0;
            return;
        end
        for (int l = 0; l < 4; l++)
            if (lane_we[l]) merged[l*8 +: 8] = wr_data[l*8 +: 8];
        commit   = lane_we[int'(width_cfg) / 8];
        sz       = m_q.size();
        m_pvalid = 1'b0;
        if (pop_req && sz > 0) begin
            m_pdata  = m_q.pop_front();
            m_pvalid = 1'b1;
        end
        if (commit) begin
            if (sz < cap_for(int'(width_cfg)))
                m_q.push_back(merged & (32'hFFFF_FFFF >> (31 - int'(width_cfg))));
            else
                m_ovf = 1'b1;
        end
        m_hold = merged;
    endtask

    task automatic compare_all();
        int c;
        c = m_q.size();
        check("R5 count", 32'(word_count), 32'(c));
        check("R5 empty", 32'(empty), 32'(c == 0));
        check("R2 full", 32'(full), 32'(c == cap_for(int'(width_cfg))));
        check("R8 overflow", 32'(overflow), 32'(m_ovf));
        check("R6 pop_valid", 32'(pop_valid), 32'(m_pvalid));
        check("R6 pop_data", pop_data, m_pdata);
    endtask

    task automatic drive(input logic en, input logic [3:0] we, input logic [31:0] d,
                         input logic pop);
        enable  = en;
        lane_we = we;
        wr_data = d;
        pop_req = pop;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        lane_we = 4'h0;
        pop_req = 1'b0;
    endtask

    task automatic flush_to(input logic [4:0] cfg);
        drive(1'b0, 4'h0, 32'h0, 1'b0);
        width_cfg = cfg;
        drive(1'b0, 4'h0, 32'h0, 1'b0);
        enable = 1'b1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R5 reset count", 32'(word_count), 32'd0);
        check("R5 reset empty", 32'(empty), 32'd1);
        check("R2 reset full", 32'(full), 32'd0);
        check("R8 reset overflow", 32'(overflow), 32'd0);
        check("R6 reset pop_valid", 32'(pop_valid), 32'd0);

        // 32-bit words built lane by lane
        flush_to(5'd31);
        drive(1'b1, 4'b0001, 32'h0000_0011, 1'b0);
        drive(1'b1, 4'b0010, 32'h0000_2200, 1'b0);
        drive(1'b1, 4'b0100, 32'h0033_0000, 1'b0);
        check("R3 lower lanes no commit", 32'(word_count), 32'd0);
        drive(1'b1, 4'b1000, 32'h4400_0000, 1'b0);
        check("R3 top lane commits", 32'(word_count), 32'd1);
        for (int i = 1; i <= 3; i++) drive(1'b1, 4'hF, 32'hA000_0000 + 32'(i), 1'b0);
        check("R2 full at 4", 32'(full), 32'd1);
        drive(1'b1, 4'hF, 32'hDEAD_BEEF, 1'b0);
        check("R8 overflow set", 32'(overflow), 32'd1);
        check("R8 count held", 32'(word_count), 32'd4);
        drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R4 merged word", pop_data, 32'h4433_2211);
        for (int i = 1; i <= 3; i++) begin
            drive(1'b1, 4'h0, 32'h0, 1'b1);
            check("R6 order", pop_data, 32'hA000_0000 + 32'(i));
        end
        check("R8 overflow sticky", 32'(overflow), 32'd1);
        drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R7 empty pop no valid", 32'(pop_valid), 32'd0);
        check("R7 empty pop data held", pop_data, 32'hA000_0003);

        // 24-bit words
        flush_to(5'd23);
        check("R9 overflow cleared", 32'(overflow), 32'd0);
        drive(1'b1, 4'b1000, 32'hFF00_0000, 1'b0);
        check("R3 lane above width", 32'(word_count), 32'd0);
        drive(1'b1, 4'b0100, 32'h0012_3456, 1'b0);
        drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R1 24-bit mask", pop_data, 32'h0012_0000);

        // 16-bit words, depth 8, then a flush with activity
        flush_to(5'd15);
        for (int i = 0; i < 8; i++) drive(1'b1, 4'b0011, 32'hBEEF_0000 + 32'(i), 1'b0);
        check("R2 full at 8", 32'(full), 32'd1);
        drive(1'b0, 4'hF, 32'h1234_5678, 1'b1);
        check("R9 flushed count", 32'(word_count), 32'd0);
        check("R9 pop ignored", 32'(pop_valid), 32'd0);

        // 12-bit words
        width_cfg = 5'd11;
        drive(1'b0, 4'h0, 32'h0, 1'b0);
        check("R9 still empty", 32'(word_count), 32'd0);
        drive(1'b1, 4'b0011, 32'h0000_FFFF, 1'b0);
        drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R1 12-bit mask", pop_data, 32'h0000_0FFF);

        // 6-bit words, depth 16
        flush_to(5'd5);
        drive(1'b1, 4'b0001, 32'h0000_00FF, 1'b0);
        drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R10 narrow byte", pop_data, 32'h0000_003F);
        for (int i = 0; i < 16; i++) drive(1'b1, 4'b0001, 32'(i), 1'b0);
        check("R2 full at 16", 32'(full), 32'd1);
        drive(1'b1, 4'b0001, 32'h0000_0021, 1'b1);
        check("R8 push dropped with pop", 32'(word_count), 32'd15);
        check("R8 overflow on full", 32'(overflow), 32'd1);
        drive(1'b1, 4'b0001, 32'h0000_0022, 1'b1);
        check("R6 push and pop", 32'(word_count), 32'd15);
        for (int i = 0; i < 15; i++) drive(1'b1, 4'h0, 32'h0, 1'b1);
        check("R6 last word", pop_data, 32'h0000_0022);
        check("R5 drained", 32'(empty), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule